// File: doc/BRIEF.md
# DSP Pointer Address Generator

This block holds four address pointers and steps them without help from the main arithmetic datapath. Each access names one pointer, picks whether the step is applied after the access (post-modify) or before it (pre-modify), and gives a signed step. One clock edge later the block presents the effective address for the memory access, together with the pointer's updated value. The updated value is written back into the pointer register on that same edge.

Every pointer has its own addressing mode and its own configuration:
- **Plain linear stepping.**
- **Ring buffer with explicit bounds.** Two inclusive limits bound the buffer. Stepping above the upper limit continues from the lower limit, and stepping below the lower limit continues from the upper limit.
- **Ring buffer by length.** The buffer begins on a power-of-two aligned base and the wrap is taken modulo a length.
- **Reversed-carry stepping.** This serves radix-2 FFT data: the step is added with the carry moving from the most significant bit of a k-bit index field toward its least significant bit, and all bits above the field stay as they are.

The block keeps no hidden sequence state. Each access is a single-cycle transaction: idle, then an issued access, then a result valid for exactly one cycle. Software-like control is limited to three things:
- a configuration write per pointer;
- a direct pointer load;
- the access command.

Top module: `agu_top`

## Requirements
- R1: After reset every pointer is 0, every pointer is in linear mode, and `ea_valid`, `ea` and `ptr_new` are 0.
- R2: A load writes `ld_val` into the selected pointer. When a load and an access target the same pointer in the same cycle, the loaded value is what the register keeps, and the access reports results computed from the old value.
- R3: In post-modify (`acc_pre`=0), `ea` equals the pointer value before the step. `ea_valid` is 1 exactly in the cycle after `acc_en` was 1.
- R4: In pre-modify (`acc_pre`=1), `ea` equals the stepped value. In both post-modify and pre-modify, `ptr_new` is the stepped value and the pointer register holds it afterwards.
- R5: Mode 0 (linear) adds the sign-extended step modulo 2^AW.
- R6: Mode 1 (bounded ring), upward: if the pointer plus the step exceeds the upper limit `hi`, the result is `lo + (sum - hi - 1)`. This holds for |step| <= hi-lo+1.
- R7: Mode 1 (bounded ring), downward: if the pointer plus the step falls below `lo`, the result is `hi - (lo - sum - 1)`.
- R8: Mode 2 (length ring) works as follows. The base is the pointer with its low k bits cleared. The offset is the low k bits. The new offset is (offset + step) brought back into 0..L-1 by one subtraction or addition of L, where L = `hi`. The result is base | new offset.
- R9: Mode 3 (reversed carry) steps the low k bits as a bit-reversed counter and leaves the upper bits unchanged. With k=3 and step +1 starting from offset 0, the offsets visited are 0,4,2,6,1,5,3,7 and then 0 again. Step -1 from offset 0 gives offset 7.
- R10: An access or load on one pointer leaves the other pointers unchanged.
- R11: A configuration write changes mode and limits but leaves the pointer value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Pointer to configure |
| cfg_mode | input | 2 | Mode: 0 linear, 1 bounded ring, 2 length ring, 3 reversed carry |
| cfg_lo | input | 16 | Lower limit (mode 1) |
| cfg_hi | input | 16 | Upper limit (mode 1) or length L (mode 2) |
| cfg_k | input | 5 | Field width k in bits (modes 2 and 3) |
| ld_we | input | 1 | Pointer load strobe |
| ld_sel | input | 2 | Pointer to load |
| ld_val | input | 16 | Value to load |
| acc_en | input | 1 | Access strobe |
| acc_sel | input | 2 | Pointer used by the access |
| acc_pre | input | 1 | 1 = pre-modify, 0 = post-modify |
| acc_step | input | 8 | Signed step (two's complement) |
| ea | output | 16 | Effective address |
| ptr_new | output | 16 | Stepped pointer value |
| ea_valid | output | 1 | Result valid, one cycle after the access |

## Verification
Linear stepping is tried with positive and negative steps and with an underflow through zero, which separates sign extension from zero extension. The bounded ring is driven across its upper edge, across its lower edge, and by steps larger than one that land beyond an edge. These cases distinguish a reset-to-start from a carried-over remainder, and they separate the upward wrap from the downward wrap. The length ring is run with an offset that passes L and with one that goes negative, which shows that the base bits stay fixed. The reversed-carry mode walks a full eight-point cycle and takes one backward step, so that an ordinary carry or a mirrored field would show up at once. Same-cycle load and access, and configuration rewrites, expose write priority and any leakage between pointers.

// File: rtl/agu_pkg.sv
package agu_pkg;
    typedef enum logic [1:0] {
        AM_LINEAR      = 2'd0,
        AM_RING_BOUNDS = 2'd1,
        AM_RING_LEN    = 2'd2,
        AM_BITREV      = 2'd3
    } agu_mode_e;
endpackage

// File: rtl/agu_bitrev.sv
// Mirrors the low k bits of x into y; bits of y at and above k are zero.
module agu_bitrev #(
    parameter int AW = 16,
    parameter int KW = $clog2(AW + 1)
) (
    input  logic [AW-1:0] x,
    input  logic [KW-1:0] k,
    output logic [AW-1:0] y
);
    logic [AW-1:0] mirror_all;

    always_comb begin
        for (int i = 0; i < AW; i++) begin
            mirror_all[i] = x[AW-1-i];
        end
    end

    // Shifting the full mirror right by AW-k leaves only the mirrored k-bit field.
    assign y = mirror_all >> (KW'(AW) - k);
endmodule

// File: rtl/agu_ptr_bank.sv
module agu_ptr_bank
    import agu_pkg::*;
#(
    parameter int NPTR = 4,
    parameter int AW   = 16,
    parameter int KW   = $clog2(AW + 1),
    parameter int SELW = $clog2(NPTR)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [SELW-1:0] cfg_sel,
    input  logic [1:0]      cfg_mode,
    input  logic [AW-1:0]   cfg_lo,
    input  logic [AW-1:0]   cfg_hi,
    input  logic [KW-1:0]   cfg_k,
    input  logic            ld_we,
    input  logic [SELW-1:0] ld_sel,
    input  logic [AW-1:0]   ld_val,
    input  logic            upd_we,
    input  logic [SELW-1:0] upd_sel,
    input  logic [AW-1:0]   upd_val,
    input  logic [SELW-1:0] rd_sel,
    output logic [AW-1:0]   rd_ptr,
    output agu_mode_e       rd_mode,
    output logic [AW-1:0]   rd_lo,
    output logic [AW-1:0]   rd_hi,
    output logic [KW-1:0]   rd_k
);
    logic [AW-1:0] ptr_q  [NPTR];
    agu_mode_e     mode_q [NPTR];
    logic [AW-1:0] lo_q   [NPTR];
    logic [AW-1:0] hi_q   [NPTR];
    logic [KW-1:0] k_q    [NPTR];

    // Pointer registers: a load overrides the access write-back.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NPTR; i++) begin
                ptr_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NPTR; i++) begin
                if (ld_we && ld_sel == SELW'(i)) begin
                    ptr_q[i] <= ld_val;
                end else if (upd_we && upd_sel == SELW'(i)) begin
                    ptr_q[i] <= upd_val;
                end
            end
        end
    end

    // Per-pointer configuration.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NPTR; i++) begin
                mode_q[i] <= AM_LINEAR;
                lo_q[i]   <= '0;
                hi_q[i]   <= '0;
                k_q[i]    <= '0;
            end
        end else if (cfg_we) begin
            for (int i = 0; i < NPTR; i++) begin
                if (cfg_sel == SELW'(i)) begin
                    mode_q[i] <= agu_mode_e'(cfg_mode);
                    lo_q[i]   <= cfg_lo;
                    hi_q[i]   <= cfg_hi;
                    k_q[i]    <= cfg_k;
                end
            end
        end
    end

    assign rd_ptr  = ptr_q[rd_sel];
    assign rd_mode = mode_q[rd_sel];
    assign rd_lo   = lo_q[rd_sel];
    assign rd_hi   = hi_q[rd_sel];
    assign rd_k    = k_q[rd_sel];

    for (genvar g = 0; g < NPTR; g++) begin : g_chk
        // R2: a load always lands in the selected register.
        a_r2_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
            (ld_we && ld_sel == SELW'(g)) |=> ptr_q[g] == $past(ld_val));
        // R10, R11: a pointer that is neither loaded nor updated keeps its value.
        a_r10_untouched_stable: assert property (@(posedge clk) disable iff (!rst_n)
            (!(ld_we && ld_sel == SELW'(g)) && !(upd_we && upd_sel == SELW'(g)))
            |=> $stable(ptr_q[g]));
    end
endmodule

// File: rtl/agu_step_unit.sv
module agu_step_unit
    import agu_pkg::*;
#(
    parameter int AW = 16,
    parameter int SW = 8,
    parameter int KW = $clog2(AW + 1)
) (
    input  logic [AW-1:0] cur,
    input  logic [SW-1:0] step,
    input  agu_mode_e     mode,
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] hi,
    input  logic [KW-1:0] k,
    output logic [AW-1:0] nxt
);
    localparam int WW = AW + 2;

    logic signed [WW-1:0] step_x, cur_x, lo_x, hi_x;
    logic [AW-1:0] fmask;
    logic [AW-1:0] lin_res, ring_res, len_res, rev_res;
    logic signed [WW-1:0] ring_sum, ring_wide, len_off, len_len, len_sum;
    logic [AW-1:0] cur_mirror, mirror_sum, sum_mirror;
    logic [1:0] unused_hi;

    assign step_x = WW'($signed(step));
    assign cur_x  = $signed({2'b00, cur});
    assign lo_x   = $signed({2'b00, lo});
    assign hi_x   = $signed({2'b00, hi});

    // Mask of the k-bit index field.
    always_comb begin
        for (int i = 0; i < AW; i++) begin
            fmask[i] = (i < int'(k));
        end
    end

    assign lin_res = cur + step_x[AW-1:0];

    // Ring with inclusive lower and upper limits.
    assign ring_sum = cur_x + step_x;
    always_comb begin
        if (ring_sum > hi_x) begin
            ring_wide = lo_x + (ring_sum - hi_x) - WW'(1);
        end else if (ring_sum < lo_x) begin
            ring_wide = hi_x - (lo_x - ring_sum) + WW'(1);
        end else begin
            ring_wide = ring_sum;
        end
    end
    assign ring_res  = ring_wide[AW-1:0];
    assign unused_hi = ring_wide[WW-1:AW] ^ len_sum[WW-1:AW];

    // Ring by length on an aligned base.
    assign len_off = $signed({2'b00, cur & fmask});
    assign len_len = $signed({2'b00, hi});
    always_comb begin
        len_sum = len_off + step_x;
        if (len_sum >= len_len) begin
            len_sum = len_sum - len_len;
        end else if (len_sum < 0) begin
            len_sum = len_sum + len_len;
        end
    end
    assign len_res = (cur & ~fmask) | (len_sum[AW-1:0] & fmask);

    // Reversed carry: mirror, add, mirror back.
    agu_bitrev #(.AW(AW), .KW(KW)) u_mirror_in (
        .x (cur),
        .k (k),
        .y (cur_mirror)
    );
    assign mirror_sum = cur_mirror + step_x[AW-1:0];
    agu_bitrev #(.AW(AW), .KW(KW)) u_mirror_out (
        .x (mirror_sum),
        .k (k),
        .y (sum_mirror)
    );
    assign rev_res = (cur & ~fmask) | (sum_mirror & fmask);

    always_comb begin
        unique case (mode)
            AM_LINEAR:      nxt = lin_res;
            AM_RING_BOUNDS: nxt = ring_res;
            AM_RING_LEN:    nxt = len_res;
            AM_BITREV:      nxt = rev_res;
            default:        nxt = lin_res;
        endcase
    end
endmodule

// File: rtl/agu_top.sv
module agu_top
    import agu_pkg::*;
#(
    parameter int NPTR = 4,
    parameter int AW   = 16,
    parameter int SW   = 8,
    parameter int KW   = $clog2(AW + 1),
    parameter int SELW = $clog2(NPTR)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [SELW-1:0] cfg_sel,
    input  logic [1:0]      cfg_mode,
    input  logic [AW-1:0]   cfg_lo,
    input  logic [AW-1:0]   cfg_hi,
    input  logic [KW-1:0]   cfg_k,
    input  logic            ld_we,
    input  logic [SELW-1:0] ld_sel,
    input  logic [AW-1:0]   ld_val,
    input  logic            acc_en,
    input  logic [SELW-1:0] acc_sel,
    input  logic            acc_pre,
    input  logic [SW-1:0]   acc_step,
    output logic [AW-1:0]   ea,
    output logic [AW-1:0]   ptr_new,
    output logic            ea_valid
);
    logic [AW-1:0] rd_ptr, rd_lo, rd_hi, step_nxt;
    logic [KW-1:0] rd_k;
    agu_mode_e     rd_mode;

    agu_ptr_bank #(.NPTR(NPTR), .AW(AW), .KW(KW), .SELW(SELW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_we  (cfg_we),
        .cfg_sel (cfg_sel),
        .cfg_mode(cfg_mode),
        .cfg_lo  (cfg_lo),
        .cfg_hi  (cfg_hi),
        .cfg_k   (cfg_k),
        .ld_we   (ld_we),
        .ld_sel  (ld_sel),
        .ld_val  (ld_val),
        .upd_we  (acc_en),
        .upd_sel (acc_sel),
        .upd_val (step_nxt),
        .rd_sel  (acc_sel),
        .rd_ptr  (rd_ptr),
        .rd_mode (rd_mode),
        .rd_lo   (rd_lo),
        .rd_hi   (rd_hi),
        .rd_k    (rd_k)
    );

    agu_step_unit #(.AW(AW), .SW(SW), .KW(KW)) u_step (
        .cur (rd_ptr),
        .step(acc_step),
        .mode(rd_mode),
        .lo  (rd_lo),
        .hi  (rd_hi),
        .k   (rd_k),
        .nxt (step_nxt)
    );

    // Result registers: one cycle from access to effective address.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ea       <= '0;
            ptr_new  <= '0;
            ea_valid <= 1'b0;
        end else begin
            ea_valid <= acc_en;
            if (acc_en) begin
                ea      <= acc_pre ? step_nxt : rd_ptr;
                ptr_new <= step_nxt;
            end
        end
    end

    // Checker helpers: step magnitude and ring span.
    int step_mag, ring_span;
    always_comb begin
        step_mag  = int'($signed(acc_step));
        if (step_mag < 0) step_mag = -step_mag;
        ring_span = int'(rd_hi) - int'(rd_lo) + 1;
    end

    // R3: result valid exactly one cycle after an access.
    a_r3_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en |=> ea_valid);
    a_r3_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |=> !ea_valid);
    // R3: post-modify presents the old pointer.
    a_r3_post_old_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_pre) |=> ea == $past(rd_ptr));
    // R4: pre-modify presents the stepped pointer.
    a_r4_pre_new_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_pre) |=> ea == ptr_new);
    // R6, R7: bounded ring stays inside its limits.
    a_r6_ring_inside: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && rd_mode == AM_RING_BOUNDS && rd_ptr >= rd_lo && rd_ptr <= rd_hi
         && step_mag <= ring_span)
        |=> (ptr_new >= $past(rd_lo) && ptr_new <= $past(rd_hi)));
    // R9: reversed-carry stepping keeps bits above the field.
    a_r9_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && rd_mode == AM_BITREV)
        |=> ((ptr_new ^ $past(rd_ptr)) >> $past(rd_k)) == '0);
endmodule

// File: tb/tb_agu_top.sv
`timescale 1ns/1ps
module tb_agu_top;
    localparam int AW = 16;
    localparam int SW = 8;
    localparam int KW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = '0;
    logic [1:0]    cfg_mode = '0;
    logic [AW-1:0] cfg_lo = '0;
    logic [AW-1:0] cfg_hi = '0;
    logic [KW-1:0] cfg_k = '0;
    logic          ld_we = 1'b0;
    logic [1:0]    ld_sel = '0;
    logic [AW-1:0] ld_val = '0;
    logic          acc_en = 1'b0;
    logic [1:0]    acc_sel = '0;
    logic          acc_pre = 1'b0;
    logic [SW-1:0] acc_step = '0;
    logic [AW-1:0] ea, ptr_new;
    logic          ea_valid;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    agu_top dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_mode(cfg_mode),
        .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .cfg_k(cfg_k),
        .ld_we(ld_we), .ld_sel(ld_sel), .ld_val(ld_val),
        .acc_en(acc_en), .acc_sel(acc_sel), .acc_pre(acc_pre), .acc_step(acc_step),
        .ea(ea), .ptr_new(ptr_new), .ea_valid(ea_valid)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic configure(input int sel, input int mode, input int lo, input int hi, input int k);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_mode = 2'(mode);
        cfg_lo = AW'(lo); cfg_hi = AW'(hi); cfg_k = KW'(k);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic load(input int sel, input int val);
        @(negedge clk);
        ld_we = 1'b1; ld_sel = 2'(sel); ld_val = AW'(val);
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic access(input string tag, input int sel, input bit pre, input int step,
                          input int exp_ea, input int exp_ptr);
        @(negedge clk);
        acc_en = 1'b1; acc_sel = 2'(sel); acc_pre = pre; acc_step = SW'(step);
        @(negedge clk);
        acc_en = 1'b0;
        check({tag, " valid"}, int'(ea_valid), 1);
        check({tag, " ea"}, int'(ea), exp_ea);
        check({tag, " ptr_new"}, int'(ptr_new), exp_ptr);
    endtask

    task automatic t_reset();
        check("R1 valid", int'(ea_valid), 0);
        check("R1 ea", int'(ea), 0);
        check("R1 ptr_new", int'(ptr_new), 0);
        // Linear default: step +2 from 0 on pointer 2.
        access("R1 default linear", 2, 1'b0, 2, 0, 2);
        @(negedge clk);
        check("R3 valid drops", int'(ea_valid), 0);
    endtask

    task automatic t_linear();
        load(0, 100);
        access("R3 post", 0, 1'b0, 3, 100, 103);
        access("R4 pre", 0, 1'b1, -5, 98, 98);
        load(0, 0);
        access("R5 underflow", 0, 1'b0, -1, 0, 16'hFFFF);
        access("R5 wrap up", 0, 1'b0, 1, 16'hFFFF, 0);
    endtask

    task automatic t_bounds();
        configure(1, 1, 20, 27, 0);
        load(1, 26);
        access("R6 to end", 1, 1'b0, 1, 26, 27);
        access("R6 past end", 1, 1'b0, 1, 27, 20);
        access("R7 pre below start", 1, 1'b1, -1, 27, 27);
        load(1, 25);
        access("R6 big step", 1, 1'b0, 4, 25, 21);
        load(1, 21);
        access("R7 big step down", 1, 1'b0, -3, 21, 26);
    endtask

    task automatic t_length();
        configure(2, 2, 0, 10, 4);
        load(2, 16'h35);
        access("R8 inside", 2, 1'b0, 3, 16'h35, 16'h38);
        access("R8 past length", 2, 1'b0, 3, 16'h38, 16'h31);
        access("R8 below base", 2, 1'b1, -2, 16'h39, 16'h39);
    endtask

    task automatic t_bitrev();
        int seq[8] = '{0, 4, 2, 6, 1, 5, 3, 7};
        configure(3, 3, 0, 0, 3);
        load(3, 16'h40);
        for (int i = 0; i < 8; i++) begin
            access("R9 sequence", 3, 1'b0, 1, 16'h40 + seq[i], 16'h40 + seq[(i + 1) % 8]);
        end
        access("R9 backward", 3, 1'b0, -1, 16'h40, 16'h47);
        configure(3, 3, 0, 0, 4);
        load(3, 16'h20);
        access("R9 k4", 3, 1'b0, 1, 16'h20, 16'h28);
    endtask

    task automatic t_priority();
        load(0, 7);
        @(negedge clk);
        ld_we = 1'b1; ld_sel = 2'd0; ld_val = AW'(500);
        acc_en = 1'b1; acc_sel = 2'd0; acc_pre = 1'b0; acc_step = SW'(1);
        @(negedge clk);
        ld_we = 1'b0; acc_en = 1'b0;
        check("R2 old ea", int'(ea), 7);
        check("R2 old ptr_new", int'(ptr_new), 8);
        access("R2 load kept", 0, 1'b0, 0, 500, 500);
        // R10: pointer 3 untouched by pointer 0 traffic.
        access("R10 other pointer", 3, 1'b0, 0, 16'h28, 16'h28);
        // R11: configuration keeps the pointer.
        configure(0, 1, 0, 1000, 0);
        access("R11 cfg keeps ptr", 0, 1'b0, 0, 500, 500);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_linear();
        t_bounds();
        t_length();
        t_bitrev();
        t_priority();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule